// File: doc/BRIEF.md
# Video Test Pattern Stream Source

This block is a stream source that emits an endless sequence of synthetic video frames, one 24-bit RGB pixel per transfer, so that a downstream video consumer can be exercised without a camera or frame store. Frames are 640 pixels wide and 480 lines tall by default. The start of each frame and the end of each line are marked with sideband flags, and the consumer sets the pace through its ready signal. Blanking intervals and sync pulses are not generated.

A 2-bit select input chooses between colour bars, a horizontal grey ramp and a flat colour. The select is taken only when the first pixel of a frame is formed, so every frame is drawn with a single pattern. The source runs on one clock with an active-low synchronous reset and holds its valid signal high from the first cycle after reset.

Top module: `vidpat_stream_src`

## Requirements
- R1: While `rst_n` is low, `m_tvalid` is 0 one clock later. The first beat presented after reset is column 0, row 0, with `m_tuser` high.
- R2: A beat with `m_tvalid` high and `m_tready` low is held: in the next cycle `m_tvalid` is still high and `m_tdata`, `m_tuser` and `m_tlast` are unchanged.
- R3: Once raised after reset, `m_tvalid` stays high on every cycle until the next reset.
- R4: `m_tuser` is 1 on the pixel at column 0 of row 0, and 0 on every other pixel.
- R5: `m_tlast` is 1 on the pixel at column H_ACTIVE-1 (639 by default) of every line, and 0 on every other pixel.
- R6: Accepted pixels run in raster order, column first, then row. After the pixel at the last column of row V_ACTIVE-1 is accepted, the next beat is column 0, row 0 with `m_tuser` high, with no idle cycle between them.
- R7: `m_tdata` places blue in bits [7:0], green in [15:8] and red in [23:16], and bits [31:24] are always 0.
- R8: Select codes 0 and 3 give colour bars. The line is split into 8 bars of H_ACTIVE/8 pixels (80 by default). From left to right the bars are white FFFFFF, yellow FFFF00, cyan 00FFFF, green 00FF00, magenta FF00FF, red FF0000, blue 0000FF and black 000000, written as R,G,B hex.
- R9: Select code 1 gives a ramp. Red, green and blue all equal the column index shifted right by 2 and are clipped to 255, so the value is 159 at column 639.
- R10: Select code 2 gives a flat colour. Every pixel equals the parameter FLAT_RGB, default R=1F, G=7F, B=D0.
- R11: `pat_sel` is sampled only in the clock cycle that loads a frame's first pixel onto the outputs. That is the first cycle after reset, or the cycle in which the frame's last pixel is accepted. A change on `pat_sel` at any other time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 2 | Pattern select: 0/3 bars, 1 ramp, 2 flat |
| m_tready | input | 1 | Consumer ready |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | 32 | Pixel word {8'h00, R, G, B} |
| m_tuser | output | 1 | Start-of-frame flag |
| m_tlast | output | 1 | End-of-line flag |

## Verification
The hardest case to reach is a new pattern select arriving while the final pixel of a frame sits on the bus and the consumer keeps stalling it. The select must then be taken on exactly the edge of acceptance, and its earlier values must be ignored. The bench builds the source with a 4-line frame, so that many frame wraps occur quickly. At each frame's last pixel it drives the next select value under random ready duty cycles, and it also toggles the select at random points mid-frame. A reset asserted partway through a frame checks that output restarts cleanly at the first pixel.

// File: rtl/vidpat_pkg.sv
package vidpat_pkg;

  typedef enum logic [1:0] {
    PAT_BARS     = 2'd0,
    PAT_RAMP     = 2'd1,
    PAT_FLAT     = 2'd2,
    PAT_BARS_ALT = 2'd3
  } pat_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam int BAR_COUNT = 8;

  // Bar k: red off for k[1], green off for k[2], blue off for k[0].
  function automatic rgb_t bar_rgb(input logic [2:0] k);
    rgb_t p;
    p.r = {8{~k[1]}};
    p.g = {8{~k[2]}};
    p.b = {8{~k[0]}};
    return p;
  endfunction

  // Grey level of a ramp column, clipped to the 8-bit channel range.
  function automatic logic [7:0] ramp_level(input int unsigned col,
                                           input int unsigned shift);
    int unsigned v;
    v = col >> shift;
    if (v > 255) v = 255;
    return 8'(v);
  endfunction

endpackage

// File: rtl/vidpat_raster.sv
module vidpat_raster #(
  parameter  int H_ACTIVE  = 640,
  parameter  int V_ACTIVE  = 480,
  parameter  int BARS      = 8,
  localparam int COL_W     = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1,
  localparam int ROW_W     = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1,
  localparam int BAR_PIX   = H_ACTIVE / BARS,
  localparam int BPOS_W    = (BAR_PIX > 1) ? $clog2(BAR_PIX) : 1,
  localparam int BAR_IDX_W = (BARS > 1) ? $clog2(BARS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  output logic [COL_W-1:0]     col,
  output logic [ROW_W-1:0]     row,
  output logic [BAR_IDX_W-1:0] bar_idx,
  output logic                 at_line_end,
  output logic                 at_frame_end,
  output logic                 at_frame_start
);

  logic [COL_W-1:0]     col_q;
  logic [ROW_W-1:0]     row_q;
  logic [BAR_IDX_W-1:0] bar_q;
  logic [BPOS_W-1:0]    bpos_q;
  logic                 bar_edge;

  assign at_line_end    = (col_q == COL_W'(H_ACTIVE - 1));
  assign at_frame_end   = at_line_end && (row_q == ROW_W'(V_ACTIVE - 1));
  assign at_frame_start = (col_q == '0) && (row_q == '0);
  assign bar_edge       = (bpos_q == BPOS_W'(BAR_PIX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      bar_q  <= '0;
      bpos_q <= '0;
    end else if (step) begin
      if (at_line_end) begin
        col_q  <= '0;
        bar_q  <= '0;
        bpos_q <= '0;
        row_q  <= at_frame_end ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
        if (bar_edge) begin
          bpos_q <= '0;
          bar_q  <= bar_q + 1'b1;
        end else begin
          bpos_q <= bpos_q + 1'b1;
        end
      end
    end
  end

  assign col     = col_q;
  assign row     = row_q;
  assign bar_idx = bar_q;

  // R6
  wrap_to_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_frame_end |=> at_frame_start);

  // R6
  next_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_line_end && !at_frame_end |=> col_q == '0 && row_q == $past(row_q) + 1'b1);

  // R8
  bar_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bar_q) == int'(col_q) / BAR_PIX);

endmodule

// File: rtl/vidpat_shade.sv
module vidpat_shade
  import vidpat_pkg::*;
#(
  parameter int          COL_W      = 10,
  parameter int          BAR_IDX_W  = 3,
  parameter int          RAMP_SHIFT = 2,
  parameter logic [23:0] FLAT_RGB   = 24'h1F7FD0
) (
  input  pat_e                 pattern,
  input  logic [COL_W-1:0]     col,
  input  logic [BAR_IDX_W-1:0] bar_idx,
  output rgb_t                 pixel
);

  logic [7:0] grey;

  assign grey = ramp_level(int'(col), RAMP_SHIFT);

  always_comb begin
    unique case (pattern)
      PAT_RAMP: pixel = '{r: grey, g: grey, b: grey};
      PAT_FLAT: pixel = rgb_t'(FLAT_RGB);
      default:  pixel = bar_rgb(3'(bar_idx));
    endcase
  end

endmodule

// File: rtl/vidpat_beat_reg.sv
module vidpat_beat_reg #(
  parameter int TDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TDATA_W-1:0] nxt_data,
  input  logic               nxt_sof,
  input  logic               nxt_eol,
  output logic               tvalid,
  output logic [TDATA_W-1:0] tdata,
  output logic               tuser,
  output logic               tlast
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvalid <= 1'b0;
      tdata  <= '0;
      tuser  <= 1'b0;
      tlast  <= 1'b0;
    end else if (load) begin
      tvalid <= 1'b1;
      tdata  <= nxt_data;
      tuser  <= nxt_sof;
      tlast  <= nxt_eol;
    end
  end

endmodule

// File: rtl/vidpat_stream_src.sv
module vidpat_stream_src
  import vidpat_pkg::*;
#(
  parameter  int          H_ACTIVE   = 640,
  parameter  int          V_ACTIVE   = 480,
  parameter  int          RAMP_SHIFT = 2,
  parameter  logic [23:0] FLAT_RGB   = 24'h1F7FD0,
  parameter  int          TDATA_W    = 32,
  localparam int          COL_W      = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1,
  localparam int          ROW_W      = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1,
  localparam int          BAR_IDX_W  = $clog2(BAR_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pat_sel,
  input  logic               m_tready,
  output logic               m_tvalid,
  output logic [TDATA_W-1:0] m_tdata,
  output logic               m_tuser,
  output logic               m_tlast
);

  logic                 load;
  logic                 accept;
  logic [COL_W-1:0]     gen_col;
  logic [ROW_W-1:0]     gen_row;
  logic [BAR_IDX_W-1:0] gen_bar;
  logic                 gen_eol;
  logic                 gen_eof;
  logic                 gen_sof;
  pat_e                 frame_pat_q;
  pat_e                 pat_now;
  rgb_t                 pix;
  logic [TDATA_W-1:0]   nxt_word;

  // Output slot refills when empty or when its beat is taken.
  assign accept = m_tvalid && m_tready;
  assign load   = !m_tvalid || m_tready;

  vidpat_raster #(
    .H_ACTIVE(H_ACTIVE),
    .V_ACTIVE(V_ACTIVE),
    .BARS    (BAR_COUNT)
  ) u_raster (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (load),
    .col           (gen_col),
    .row           (gen_row),
    .bar_idx       (gen_bar),
    .at_line_end   (gen_eol),
    .at_frame_end  (gen_eof),
    .at_frame_start(gen_sof)
  );

  assign pat_now = gen_sof ? pat_e'(pat_sel) : frame_pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              frame_pat_q <= PAT_BARS;
    else if (load && gen_sof) frame_pat_q <= pat_e'(pat_sel);
  end

  vidpat_shade #(
    .COL_W     (COL_W),
    .BAR_IDX_W (BAR_IDX_W),
    .RAMP_SHIFT(RAMP_SHIFT),
    .FLAT_RGB  (FLAT_RGB)
  ) u_shade (
    .pattern(pat_now),
    .col    (gen_col),
    .bar_idx(gen_bar),
    .pixel  (pix)
  );

  always_comb begin
    nxt_word       = '0;
    nxt_word[23:0] = {pix.r, pix.g, pix.b};
  end

  vidpat_beat_reg #(
    .TDATA_W(TDATA_W)
  ) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .nxt_data(nxt_word),
    .nxt_sof (gen_sof),
    .nxt_eol (gen_eol),
    .tvalid  (m_tvalid),
    .tdata   (m_tdata),
    .tuser   (m_tuser),
    .tlast   (m_tlast)
  );

  // R1
  idle_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !m_tvalid);

  // R1
  first_beat_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> m_tuser);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  // R3
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |=> m_tvalid);

  // R4
  sof_eol_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !(m_tuser && m_tlast));

  // R6
  eol_then_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && m_tlast |=> !m_tlast);

  // R11
  pat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_sof && !gen_eof |=> $stable(pat_now));

endmodule

// File: tb/sim_vidpat_stream_src.sv
module sim_vidpat_stream_src;

  localparam int          CLK_PERIOD = 10;
  localparam int          H          = 640;
  localparam int          V          = 4;
  localparam logic [23:0] FLAT       = 24'h1F7FD0;
  localparam int          WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pat_sel = 2'd1;
  logic        tready = 1'b0;
  logic        tvalid;
  logic [31:0] tdata;
  logic        tuser;
  logic        tlast;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int exp_col, exp_row, exp_pat, frames_done, ready_pct;
  bit prev_stall, first_after_rst;
  logic [31:0] prev_data;
  logic prev_user, prev_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidpat_stream_src #(
    .H_ACTIVE(H),
    .V_ACTIVE(V),
    .FLAT_RGB(FLAT)
  ) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .pat_sel (pat_sel),
    .m_tready(tready),
    .m_tvalid(tvalid),
    .m_tdata (tdata),
    .m_tuser (tuser),
    .m_tlast (tlast)
  );

  function automatic logic [31:0] want_word(int col, int pat);
    logic [23:0] c;
    int lv;
    case (pat)
      1: begin
        lv = col / 4;
        if (lv > 255) lv = 255;
        c = {8'(lv), 8'(lv), 8'(lv)};
      end
      2: c = FLAT;
      default: begin
        case (col / (H / 8))
          0: c = 24'hFFFFFF;
          1: c = 24'hFFFF00;
          2: c = 24'h00FFFF;
          3: c = 24'h00FF00;
          4: c = 24'hFF00FF;
          5: c = 24'hFF0000;
          6: c = 24'h0000FF;
          default: c = 24'h000000;
        endcase
      end
    endcase
    return {8'h00, c};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at col %0d row %0d: got %h expected %h", tag, exp_col, exp_row, got, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  task automatic do_reset(input logic [1:0] p);
    @(negedge clk);
    rst_n   = 1'b0;
    pat_sel = p;
    tready  = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R1 valid low in reset", 32'(tvalid), 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    exp_col = 0;
    exp_row = 0;
    exp_pat = int'(p);
    prev_stall = 0;
    first_after_rst = 1;
  endtask

  task automatic one_cycle();
    string dtag;
    @(negedge clk);
    tready = (($urandom % 100) < 32'(ready_pct));
    if (exp_col == H-1 && exp_row == V-1) pat_sel = 2'(frames_done % 4);
    else if (($urandom % 16) == 0) pat_sel = 2'($urandom % 4);
    #1;
    check("R3 valid held high", 32'(tvalid), 32'd1);
    if (prev_stall) begin
      check("R2 data held under stall", tdata, prev_data);
      check("R2 flags held under stall", {30'd0, tuser, tlast}, {30'd0, prev_user, prev_last});
    end
    if (first_after_rst) begin
      check("R1 first beat is start of frame", 32'(tuser), 32'd1);
      first_after_rst = 0;
    end
    if (exp_pat == 1)      dtag = "R9 ramp pixel";
    else if (exp_pat == 2) dtag = "R10 flat pixel";
    else                   dtag = "R8 bar pixel";
    if (exp_pat != 2 && ($urandom % 8) == 0) dtag = {dtag, " R11 select frozen"};
    check(dtag, tdata, want_word(exp_col, exp_pat));
    check("R7 pad byte zero", {24'd0, tdata[31:24]}, 32'd0);
    if (exp_col == 0 && exp_row == 0 && frames_done > 0)
      check("R6 wrap to start of frame", 32'(tuser), 32'd1);
    else
      check("R4 start-of-frame flag", 32'(tuser), 32'(exp_col == 0 && exp_row == 0));
    check("R5 end-of-line flag", 32'(tlast), 32'(exp_col == H-1));
    prev_data  = tdata;
    prev_user  = tuser;
    prev_last  = tlast;
    prev_stall = tvalid && !tready;
    if (tvalid && tready) begin
      if (exp_col == H-1) begin
        exp_col = 0;
        if (exp_row == V-1) begin
          exp_row = 0;
          exp_pat = int'(pat_sel);
          frames_done++;
        end else begin
          exp_row++;
        end
      end else begin
        exp_col++;
      end
    end
  endtask

  task automatic run_frames(int n);
    int target;
    target = frames_done + n;
    while (frames_done < target) begin
      case (frames_done % 3)
        0: ready_pct = 100;
        1: ready_pct = 50;
        default: ready_pct = 85;
      endcase
      one_cycle();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED0042));
    frames_done = 0;
    ready_pct = 100;
    do_reset(2'd1);
    run_frames(6);
    // Reset in the middle of a frame, then restart from the origin.
    for (int k = 0; k < 700; k++) one_cycle();
    do_reset(2'd3);
    run_frames(3);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      summary();
      $finish;
    end
  end

endmodule